// File: doc/BRIEF.md
# Serial-Bus Link Controller Register Block

This block is the host-visible register space of a serial-bus link-layer controller. A 32-bit host port reads and writes words by word address. Most of the space is plain storage, which includes the two DMA control/status words. A handful of locations behave differently. Two identifier words always return fixed values. One control word stores a constant, and another drops a self-clearing bit. There are three interrupt status registers that software clears by writing ones, each paired with a mask register. One word is a gateway to a private bank of sixteen 8-bit PHY registers.

Writing the PHY gateway word stores the value and queues a PHY transfer. The transfer completes on the next clock. A write transfer updates one PHY register and scrubs its request flag and payload from the gateway word. A read transfer clears its flag, merges the fetched byte and its index into the gateway word, and, when the matching mask bit is set, raises a status bit that drives the interrupt output.

The host port has no back-pressure. It is always ready, so every cycle with `host_en` high is one complete access. Read data is combinational from the addressed word, and `host_rdata` is valid in the same cycle that `host_en` is high with `host_we` low. The interrupt is a plain level.

Top module: `sbl_link_regs`

## Requirements
- R1: After reset, every PHY register and every host-visible word reads zero, `irq` is low, and the two fixed words still return their fixed values.
- R2: Word 0 (byte offset 0x00) always reads 0xFFC00001, and word 31 (byte offset 0x7C) always reads 0x10000001, whatever was written there.
- R3: Word 4 (byte offset 0x10) stores 0x00000008 on any write, whatever the written value.
- R4: Word 2 (byte offset 0x08) stores the written value with bit 23 forced to zero.
- R5: A write to word 5 (byte offset 0x14, the PHY gateway) with bit 30 set writes data bits 7:0 into the PHY register selected by bits 11:8. On the following clock, bit 30 and bits 15:0 of the gateway word are cleared, and all other bits keep their written value.
- R6: A gateway write with bit 31 set and bit 30 clear reads the PHY register selected by bits 27:24. On the following clock, bit 31 of the gateway word is cleared and the word is ORed with the fetched byte in bits 7:0 and the index in bits 11:8. A gateway write with neither flag set does nothing beyond storing the value.
- R7: When bits 30 and 31 are both set, only the PHY write is performed, and bit 31 stays set in the gateway word.
- R8: When a PHY read completes while bit 30 of mask word 9 (0x24) is set, bit 30 of status word 8 (0x20) becomes 1. When that mask bit is clear, the status word is unchanged.
- R9: Status words 8, 10 and 12 (0x20, 0x28, 0x30) clear each bit written as one and keep bits written as zero. A PHY-read set in the same cycle as a clear of the same bit wins.
- R10: Mask words 9, 11 and 13 (0x24, 0x2C, 0x34) store the written value directly.
- R11: `irq` is high exactly when some bit is set in both a status word and its mask word. It falls as soon as that bit is cleared or masked.
- R12: All other words, including the DMA words 46 (0xB8) and 78 (0x138), read back the last value written to them.
- R13: A host write to the gateway word in the same cycle a transfer completes stores the host value and starts that value's own request. The completing transfer still updates the PHY bank and the status bit, but its change to the gateway word is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_en | input | 1 | Access strobe; one access per cycle, always accepted |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W (7) | Word address (byte offset divided by 4) |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data for the addressed word, same cycle |
| irq | output | 1 | Level interrupt: OR of status AND mask |

## Verification
Two of this block's functions can collide in one cycle. The first is the completion of a queued PHY transfer, which lands one clock after the gateway write. It can fall together with a host write to status word 8 that clears bit 30, or with a fresh host write to the gateway word. The bench provokes both by issuing the second write in the cycle right after the gateway write. It then judges the result against a behavioural model: the set must survive the clear, and the host value must replace the discarded merge while the PHY bank still changes.

// File: rtl/sbl_pkg.sv
`timescale 1ns/1ps
package sbl_pkg;
  localparam int unsigned DW        = 32;
  localparam int unsigned PHY_IW    = 4;
  localparam int unsigned PHY_DW    = 8;
  localparam int unsigned PHY_REGS  = 1 << PHY_IW;

  // word indices (byte offset / 4)
  localparam int unsigned W_NODE    = 0;
  localparam int unsigned W_CTRL0   = 2;
  localparam int unsigned W_CTRL2   = 4;
  localparam int unsigned W_PHYACC  = 5;
  localparam int unsigned W_STAT0   = 8;   // status i at W_STAT0 + 2*i
  localparam int unsigned W_MASK0   = 9;   // mask i at W_MASK0 + 2*i
  localparam int unsigned W_IDENT   = 31;

  localparam logic [DW-1:0] NODE_VAL  = 32'hFFC0_0001;
  localparam logic [DW-1:0] IDENT_VAL = 32'h1000_0001;
  localparam logic [DW-1:0] CTRL2_VAL = 32'h0000_0008;
  localparam int unsigned   CTRL0_SC  = 23;
  localparam int unsigned   GW_WR     = 30;
  localparam int unsigned   GW_RD     = 31;
  localparam int unsigned   RD_IRQ    = 30;
  localparam logic [DW-1:0] WR_SCRUB  = 32'h4000_FFFF;

  typedef enum logic [1:0] {
    PHY_IDLE  = 2'd0,
    PHY_WRITE = 2'd1,
    PHY_READ  = 2'd2
  } phy_op_e;

  typedef struct packed {
    phy_op_e             op;
    logic [PHY_IW-1:0]   idx;
    logic [PHY_DW-1:0]   data;
  } phy_req_t;
endpackage

// File: rtl/sbl_phy_bank.sv
`timescale 1ns/1ps
module sbl_phy_bank #(
  parameter int unsigned IW = 4,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int unsigned N = 1 << IW;

  logic [DW-1:0] regs_q [N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) regs_q[i] <= '0;
    end else if (we) begin
      regs_q[idx] <= wdata;
    end
  end

  assign rdata = regs_q[idx];
endmodule

// File: rtl/sbl_irq_bank.sv
`timescale 1ns/1ps
module sbl_irq_bank #(
  parameter int unsigned NREG = 3,
  parameter int unsigned DW   = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NREG-1:0]          stat_hit,
  input  logic [NREG-1:0]          mask_hit,
  input  logic [DW-1:0]            wdata,
  input  logic [NREG-1:0][DW-1:0]  set_bits,
  output logic [NREG-1:0][DW-1:0]  status,
  output logic [NREG-1:0][DW-1:0]  mask,
  output logic                     irq
);
  logic [NREG-1:0] pend;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [DW-1:0] st_q, mk_q, clr;

    assign clr = stat_hit[g] ? wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q <= '0;
        mk_q <= '0;
      end else begin
        st_q <= (st_q & ~clr) | set_bits[g];   // set beats clear
        if (mask_hit[g]) mk_q <= wdata;
      end
    end

    assign status[g] = st_q;
    assign mask[g]   = mk_q;
    assign pend[g]   = |(st_q & mk_q);
  end

  assign irq = |pend;
endmodule

// File: rtl/sbl_word_store.sv
`timescale 1ns/1ps
module sbl_word_store #(
  parameter int unsigned AW = 7,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] ridx,
  output logic [DW-1:0] rdata
);
  localparam int unsigned WORDS = 1 << AW;

  logic [DW-1:0] mem_q [WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[widx] <= wdata;
    end
  end

  assign rdata = mem_q[ridx];
endmodule

// File: rtl/sbl_link_regs.sv
`timescale 1ns/1ps
module sbl_link_regs
  import sbl_pkg::*;
#(
  parameter int unsigned ADDR_W   = 7,
  parameter int unsigned IRQ_REGS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_en,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DW-1:0]     host_wdata,
  output logic [DW-1:0]     host_rdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_NODE  = ADDR_W'(W_NODE);
  localparam logic [ADDR_W-1:0] A_CTRL0 = ADDR_W'(W_CTRL0);
  localparam logic [ADDR_W-1:0] A_CTRL2 = ADDR_W'(W_CTRL2);
  localparam logic [ADDR_W-1:0] A_PHY   = ADDR_W'(W_PHYACC);
  localparam logic [ADDR_W-1:0] A_IDENT = ADDR_W'(W_IDENT);

  logic                         wr, wr_gw, special;
  logic [IRQ_REGS-1:0]          stat_hit, mask_hit;
  logic [IRQ_REGS-1:0][DW-1:0]  status_w, mask_w, set_vec;
  phy_req_t                     req_d, pend_q;
  logic [DW-1:0]                phyacc_q, phyacc_d;
  logic [PHY_DW-1:0]            phy_rdata;
  logic [DW-1:0]                store_wdata, store_rdata;
  logic                         pend_rd;

  assign wr    = host_en & host_we;
  assign wr_gw = wr && (host_addr == A_PHY);

  for (genvar g = 0; g < IRQ_REGS; g++) begin : g_dec
    assign stat_hit[g] = wr && (host_addr == ADDR_W'(W_STAT0 + 2*g));
    assign mask_hit[g] = wr && (host_addr == ADDR_W'(W_MASK0 + 2*g));
  end

  assign special = wr_gw | (|stat_hit) | (|mask_hit);

  // decode the gateway request; write wins over read
  always_comb begin
    req_d      = '0;
    req_d.op   = PHY_IDLE;
    if (host_wdata[GW_WR]) begin
      req_d.op   = PHY_WRITE;
      req_d.idx  = host_wdata[11:8];
      req_d.data = host_wdata[7:0];
    end else if (host_wdata[GW_RD]) begin
      req_d.op   = PHY_READ;
      req_d.idx  = host_wdata[27:24];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (wr_gw) begin
      pend_q <= req_d;
    end else begin
      pend_q <= '0;
    end
  end

  assign pend_rd = (pend_q.op == PHY_READ);

  sbl_phy_bank #(.IW(PHY_IW), .DW(PHY_DW)) u_phy (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (pend_q.op == PHY_WRITE),
    .idx   (pend_q.idx),
    .wdata (pend_q.data),
    .rdata (phy_rdata)
  );

  // gateway word: host write beats the completion merge
  always_comb begin
    phyacc_d = phyacc_q;
    if (wr_gw) begin
      phyacc_d = host_wdata;
    end else begin
      unique case (pend_q.op)
        PHY_WRITE: phyacc_d = phyacc_q & ~WR_SCRUB;
        PHY_READ: begin
          phyacc_d        = phyacc_q;
          phyacc_d[GW_RD] = 1'b0;
          phyacc_d        = phyacc_d | {16'h0, 4'h0, pend_q.idx, phy_rdata};
        end
        default: phyacc_d = phyacc_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phyacc_q <= '0;
    else        phyacc_q <= phyacc_d;
  end

  always_comb begin
    set_vec = '0;
    set_vec[0][RD_IRQ] = pend_rd & mask_w[0][RD_IRQ];
  end

  sbl_irq_bank #(.NREG(IRQ_REGS), .DW(DW)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .stat_hit (stat_hit),
    .mask_hit (mask_hit),
    .wdata    (host_wdata),
    .set_bits (set_vec),
    .status   (status_w),
    .mask     (mask_w),
    .irq      (irq)
  );

  always_comb begin
    store_wdata = host_wdata;
    if (host_addr == A_CTRL0) store_wdata[CTRL0_SC] = 1'b0;
    if (host_addr == A_CTRL2) store_wdata = CTRL2_VAL;
  end

  sbl_word_store #(.AW(ADDR_W), .DW(DW)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr & ~special),
    .widx  (host_addr),
    .wdata (store_wdata),
    .ridx  (host_addr),
    .rdata (store_rdata)
  );

  always_comb begin
    host_rdata = store_rdata;
    if (host_addr == A_NODE)  host_rdata = NODE_VAL;
    if (host_addr == A_IDENT) host_rdata = IDENT_VAL;
    if (host_addr == A_PHY)   host_rdata = phyacc_q;
    for (int i = 0; i < IRQ_REGS; i++) begin
      if (host_addr == ADDR_W'(W_STAT0 + 2*i)) host_rdata = status_w[i];
      if (host_addr == ADDR_W'(W_MASK0 + 2*i)) host_rdata = mask_w[i];
    end
  end
endmodule

module sbl_link_regs_chk
  import sbl_pkg::*;
#(
  parameter int unsigned ADDR_W   = 7,
  parameter int unsigned IRQ_REGS = 3
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         host_en,
  input logic                         host_we,
  input logic [ADDR_W-1:0]            host_addr,
  input logic [DW-1:0]                host_wdata,
  input logic [DW-1:0]                phyacc,
  input logic                         pend_rd,
  input logic [IRQ_REGS-1:0][DW-1:0]  status,
  input logic [IRQ_REGS-1:0][DW-1:0]  mask
);
  logic gw, st0_wr, mk0_wr;
  assign gw     = host_en && host_we && (host_addr == ADDR_W'(W_PHYACC));
  assign st0_wr = host_en && host_we && (host_addr == ADDR_W'(W_STAT0));
  assign mk0_wr = host_en && host_we && (host_addr == ADDR_W'(W_MASK0));

  assert_phy_wr_scrub_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (gw && host_wdata[GW_WR]) ##1 !gw |=> (!phyacc[GW_WR] && phyacc[15:0] == 16'h0));

  assert_phy_rd_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (gw && host_wdata[GW_RD] && !host_wdata[GW_WR]) ##1 !gw |=> !phyacc[GW_RD]);

  assert_rd_sets_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_rd && mask[0][RD_IRQ]) |=> status[0][RD_IRQ]);

  assert_w1c_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st0_wr && !pend_rd) |=> ((status[0] & $past(host_wdata)) == '0));

  assert_mask_direct_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mk0_wr |=> (mask[0] == $past(host_wdata)));
endmodule

bind sbl_link_regs sbl_link_regs_chk #(.ADDR_W(ADDR_W), .IRQ_REGS(IRQ_REGS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_en    (host_en),
  .host_we    (host_we),
  .host_addr  (host_addr),
  .host_wdata (host_wdata),
  .phyacc     (phyacc_q),
  .pend_rd    (pend_rd),
  .status     (status_w),
  .mask       (mask_w)
);

// File: tb/sim_sbl_link_regs.sv
`timescale 1ns/1ps
module sim_sbl_link_regs;
  localparam int AW = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          host_en = 1'b0, host_we = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [31:0]   host_wdata = '0;
  logic [31:0]   host_rdata;
  logic          irq;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sbl_link_regs #(.ADDR_W(AW), .IRQ_REGS(3)) u0 (
    .clk(clk), .rst_n(rst_n), .host_en(host_en), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .irq(irq)
  );

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_mem [128];
  logic [7:0]  m_phy [16];
  logic [31:0] m_gw;
  logic [31:0] m_st [3];
  logic [31:0] m_mk [3];
  int          m_op;       // 0 none, 1 write, 2 read
  int          m_idx;
  logic [7:0]  m_dat;

  task automatic m_reset();
    for (int i = 0; i < 128; i++) m_mem[i] = 0;
    for (int i = 0; i < 16; i++)  m_phy[i] = 0;
    for (int i = 0; i < 3; i++) begin m_st[i] = 0; m_mk[i] = 0; end
    m_gw = 0; m_op = 0; m_idx = 0; m_dat = 0;
  endtask

  function automatic logic [31:0] m_read(int a);
    case (a)
      0:  return 32'hFFC00001;
      31: return 32'h10000001;
      5:  return m_gw;
      8, 10, 12: return m_st[(a - 8) / 2];
      9, 11, 13: return m_mk[(a - 9) / 2];
      default: return m_mem[a];
    endcase
  endfunction

  function automatic logic m_irq();
    return |((m_st[0] & m_mk[0]) | (m_st[1] & m_mk[1]) | (m_st[2] & m_mk[2]));
  endfunction

  task automatic m_step(bit en, bit we, int a, logic [31:0] d);
    logic [31:0] gw_new = m_gw;
    logic [31:0] set0 = 0;
    if (m_op == 1) begin
      m_phy[m_idx] = m_dat;
      gw_new = m_gw & ~32'h4000FFFF;
    end else if (m_op == 2) begin
      gw_new = (m_gw & ~32'h80000000) | 32'(m_phy[m_idx]) | (32'(m_idx) << 8);
      if (m_mk[0][30]) set0[30] = 1'b1;
    end
    m_op = 0;
    if (en && we) begin
      case (a)
        5: begin
          gw_new = d;
          if (d[30]) begin m_op = 1; m_idx = int'(d[11:8]); m_dat = d[7:0]; end
          else if (d[31]) begin m_op = 2; m_idx = int'(d[27:24]); end
        end
        8, 10, 12: m_st[(a - 8) / 2] = m_st[(a - 8) / 2] & ~d;
        9, 11, 13: m_mk[(a - 9) / 2] = d;
        2: m_mem[a] = d & ~32'h00800000;
        4: m_mem[a] = 32'h8;
        default: m_mem[a] = d;
      endcase
    end
    m_st[0] = m_st[0] | set0;
    m_gw = gw_new;
  endtask

  // ---------------- checking ----------------
  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %08h expected %08h", tag, what, act, exp);
    end
  endtask

  // one cycle: drive, compare rdata and irq against the model, advance model
  task automatic cyc(bit en, bit we, int a, logic [31:0] d, string tag);
    @(negedge clk);
    host_en = en; host_we = we; host_addr = AW'(a); host_wdata = d;
    #1;
    check(tag, $sformatf("rdata @%0d", a), host_rdata, m_read(a));
    check("R11", "irq", {31'h0, irq}, {31'h0, m_irq()});
    @(posedge clk);
    m_step(en, we, a, d);
  endtask

  task automatic wr(int a, logic [31:0] d, string tag); cyc(1, 1, a, d, tag); endtask
  task automatic rd(int a, string tag);                 cyc(1, 0, a, 0, tag); endtask

  initial begin
    m_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    rd(0, "R1"); rd(31, "R1"); rd(2, "R1"); rd(4, "R1"); rd(5, "R1");
    rd(8, "R1"); rd(9, "R1"); rd(20, "R1"); rd(46, "R1");

    // R2 fixed words
    wr(0, 32'h12345678, "R2"); rd(0, "R2");
    wr(31, 32'h0, "R2"); rd(31, "R2");

    // R3 control 2
    wr(4, 32'hFFFFFFFF, "R3"); rd(4, "R3");
    wr(4, 32'h0, "R3"); rd(4, "R3");

    // R4 control 0 self-clearing bit
    wr(2, 32'hFFFFFFFF, "R4"); rd(2, "R4");
    wr(2, 32'h00800001, "R4"); rd(2, "R4");

    // R12 plain storage incl. DMA words
    wr(46, 32'hDEADBEEF, "R12"); wr(78, 32'h13579BDF, "R12"); wr(100, 32'hA5A5A5A5, "R12");
    rd(46, "R12"); rd(78, "R12"); rd(100, "R12");

    // R5 PHY writes
    wr(5, 32'h4F003A5C, "R5"); rd(5, "R5"); rd(5, "R5");
    for (int i = 0; i < 16; i++) begin
      wr(5, 32'h40000000 | (i << 8) | ((i * 17 + 3) & 8'hFF), "R5");
      rd(5, "R5");
    end

    // R6 PHY read, mask off: no status
    wr(5, 32'h83000000, "R6"); rd(5, "R6"); rd(8, "R8");
    wr(5, 32'h00000F0F, "R6"); rd(5, "R6"); rd(5, "R6");

    // R10 masks
    wr(9, 32'h40000000, "R10"); wr(11, 32'hFFFF0000, "R10"); wr(13, 32'h00000001, "R10");
    rd(9, "R10"); rd(11, "R10"); rd(13, "R10");

    // R8 read completion with mask set -> status, irq
    wr(5, 32'h87000000, "R8"); rd(5, "R8"); rd(8, "R8");

    // R9 write-1-to-clear
    wr(8, 32'h0, "R9"); rd(8, "R9");
    wr(8, 32'h40000000, "R9"); rd(8, "R9");

    // R9 set beats clear in the completion cycle
    wr(5, 32'h8A000000, "R9"); wr(8, 32'h40000000, "R9"); rd(8, "R9");
    wr(8, 32'hFFFFFFFF, "R9"); rd(8, "R9");

    // R11 masking drops and restores irq
    wr(5, 32'h8C000000, "R11"); rd(8, "R11");
    wr(9, 32'h0, "R11"); rd(8, "R11");
    wr(9, 32'h40000000, "R11"); rd(8, "R11");
    wr(8, 32'h40000000, "R11"); rd(8, "R11");

    // R7 both flags: write only, bit 31 kept
    wr(5, 32'hC2000155, "R7"); rd(5, "R7"); rd(8, "R7");
    wr(5, 32'h81000000, "R7"); rd(5, "R7");
    wr(8, 32'h40000000, "R7");

    // R13 host write to gateway during completion
    wr(5, 32'h84000000, "R13"); wr(5, 32'h00001234, "R13"); rd(5, "R13"); rd(8, "R13");
    wr(5, 32'h8F000000, "R13"); wr(5, 32'h40000E77, "R13"); rd(5, "R13");
    wr(5, 32'h8E000000, "R13"); rd(5, "R13");
    wr(8, 32'hFFFFFFFF, "R13"); rd(8, "R13");

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule